// File: doc/BRIEF.md
# Clock Synthesizer Divider Search Engine

This block chooses divider settings for a clock synthesizer that runs from a fixed 14.31818 MHz reference. The synthesized frequency is reference × M / (N1 × 2^N2). A controller places a target frequency in kHz on `target_khz` and pulses `start`. The engine then works through every allowed (N2, N1) pair, one pair per clock. For each pair it derives the nearest integer M, drops pairs whose M or intermediate oscillator rate falls outside its window, and keeps the pair with the smallest error. When the search ends, it presents the winner as two register bytes ready for the synthesizer.

All arithmetic is unsigned fixed point with `FRAC` fractional bits. No division is performed. The target ratio comes from a multiply by a reciprocal constant, and errors are compared as exact cross-multiplied fractions.

The control pins are plain. `start` is sampled only while `busy` is low. `done` pulses for one cycle when the result bytes become valid. The bytes and `clamped` then hold until the next accepted start. The block has no streaming interface, so it applies no back-pressure.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `busy`, `done` and `clamped` are 0, `m_byte` is 125 and `n_byte` is 0x50 (the default effective M=127, N1=18, N2=2 in packed form).
- R2: A `start` sampled high while `busy` is low launches a search. `busy` is high for exactly 124 cycles, with one pair per cycle, N2 in the outer loop from 0 to 3 and N1 in the inner loop from 3 to 33. `done` is high for exactly the one cycle after `busy` falls, and it is never high together with `busy`.
- R3: A `start` pulse while `busy` is high is ignored. Neither the running search's result nor `clamped` changes because of it.
- R4: A target below 12500 kHz (100000 kHz / 2^3) is raised to 12500 kHz. A target above 250000 kHz is lowered to 250000 kHz. `clamped` is 1 exactly when either adjustment happened, and it holds until the next accepted start.
- R5: The target ratio is r = floor(f × 76791298 / 2^20), where f is the clamped target in kHz. This is f / 14318.18 in unsigned Q20.
- R6: For each pair, p = r × N1 × 2^N2 and M = floor((p + 2^19) / 2^20). A pair with M < 3 or M > 129 is skipped.
- R7: A pair is also skipped unless N1 × floor(100000 × 76791298 / 2^20) ≤ M × 2^20 ≤ N1 × floor(250000 × 76791298 / 2^20). This keeps the intermediate rate between 100 and 250 MHz.
- R8: The error of a pair is |p − M × 2^20| / (N1 × 2^N2). A pair becomes the best only when its error is strictly smaller. On a tie, the earlier pair in search order wins. The initial best error is r / 1, with the best values preset to M=127, N1=18, N2=2.
- R9: `m_byte` = M − 2. `n_byte` = (N1 − 2) with N2 placed at bit 5, or at bit 6 when the stored N1 maximum parameter is 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch a search (sampled while idle) |
| target_khz | input | 19 | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| clamped | output | 1 | Target was moved into the reachable range |
| m_byte | output | 8 | Packed M divider byte |
| n_byte | output | 8 | Packed N1/N2 divider byte |

## Verification
The search is exercised with the following targets:
- Common pixel clocks (about 25.2, 28.3, 40, 65, 108 and 135 MHz). These land on different winning N2 values and give different trade-offs between rounding error and the oscillator window.
- The exact range edges, 12500 and 250000 kHz. These show whether clamping uses a strict or an inclusive comparison.
- Targets well outside the range (5000 and 300000 kHz). These must produce the same bytes as the edges, with `clamped` raised.

A bench model follows `busy` and `done` on every clock. A second `start` carrying a different target is injected mid-search, and the bench confirms that the first target's result is still the one reported.

// File: rtl/pll_div_search_pkg.sv
package pll_div_search_pkg;
  typedef logic [63:0] wide_t;
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/pll_freq_clamp.sv
module pll_freq_clamp
  import pll_div_search_pkg::*;
#(
  parameter int unsigned TW          = 19,
  parameter int unsigned RW          = 26,
  parameter int unsigned FRAC        = 20,
  parameter wide_t       INV         = 64'd76791298,
  parameter int unsigned VCO_MIN_KHZ = 100000,
  parameter int unsigned VCO_MAX_KHZ = 250000,
  parameter int unsigned N2_MAX      = 3
) (
  input  logic [TW-1:0] target,
  output logic [RW-1:0] ratio,
  output logic          was_clamped
);
  localparam logic [TW-1:0] F_LO = TW'(VCO_MIN_KHZ >> N2_MAX);
  localparam logic [TW-1:0] F_HI = TW'(VCO_MAX_KHZ);

  logic [TW-1:0] f_use;
  wide_t         scaled;

  always_comb begin
    was_clamped = 1'b0;
    f_use       = target;
    if (target < F_LO) begin
      f_use       = F_LO;
      was_clamped = 1'b1;
    end else if (target > F_HI) begin
      f_use       = F_HI;
      was_clamped = 1'b1;
    end
    scaled = (64'(f_use) * INV) >> FRAC;
    ratio  = scaled[RW-1:0];
  end
endmodule

// File: rtl/pll_pair_eval.sv
module pll_pair_eval
  import pll_div_search_pkg::*;
#(
  parameter int unsigned RW   = 26,
  parameter int unsigned FRAC = 20,
  parameter int unsigned N1W  = 6,
  parameter int unsigned N2W  = 2,
  parameter int unsigned MW   = 8,
  parameter int unsigned M_LO = 3,
  parameter int unsigned M_HI = 129,
  parameter wide_t       RMIN = 64'd0,
  parameter wide_t       RMAX = 64'd0
) (
  input  logic [RW-1:0]  ratio,
  input  logic [N1W-1:0] n1,
  input  logic [N2W-1:0] n2,
  output logic           ok,
  output logic [MW-1:0]  m_eff,
  output logic [RW-1:0]  err,
  output logic [RW-1:0]  den
);
  wide_t prod, m_full, mq, diff, d_full;
  logic  in_m, in_vco;

  always_comb begin
    prod   = (64'(ratio) * 64'(n1)) << n2;
    m_full = (prod + (64'd1 << (FRAC - 1))) >> FRAC;
    mq     = m_full << FRAC;
    in_m   = (m_full >= 64'(M_LO)) && (m_full <= 64'(M_HI));
    in_vco = (mq >= 64'(n1) * RMIN) && (mq <= 64'(n1) * RMAX);
    ok     = in_m && in_vco;
    m_eff  = m_full[MW-1:0];
    diff   = (prod >= mq) ? (prod - mq) : (mq - prod);
    err    = diff[RW-1:0];
    d_full = 64'(n1) << n2;
    den    = d_full[RW-1:0];
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_div_search_pkg::*;
#(
  parameter int unsigned TW          = 19,
  parameter int unsigned FRAC        = 20,
  parameter int unsigned INVW        = 27,
  parameter wide_t       INV         = 64'd76791298,
  parameter int unsigned VCO_MIN_KHZ = 100000,
  parameter int unsigned VCO_MAX_KHZ = 250000,
  parameter int unsigned N2_MAX      = 3,
  parameter int unsigned N1_MIN_ST   = 1,
  parameter int unsigned N1_MAX_ST   = 31,
  parameter int unsigned M_MIN_ST    = 1,
  parameter int unsigned M_MAX_ST    = 127,
  parameter int unsigned DEF_M       = 127,
  parameter int unsigned DEF_N1      = 18,
  parameter int unsigned DEF_N2      = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [TW-1:0]       target_khz,
  output logic                busy,
  output logic                done,
  output logic                clamped,
  output logic [BYTE_W-1:0]   m_byte,
  output logic [BYTE_W-1:0]   n_byte
);
  localparam int unsigned RW    = TW + INVW - FRAC;
  localparam int unsigned N1W   = $clog2(N1_MAX_ST + 3);
  localparam int unsigned N2W   = (N2_MAX > 0) ? $clog2(N2_MAX + 1) : 1;
  localparam int unsigned MW    = $clog2(M_MAX_ST + 3);
  localparam logic [N1W-1:0] N1_LO = N1W'(N1_MIN_ST + 2);
  localparam logic [N1W-1:0] N1_HI = N1W'(N1_MAX_ST + 2);
  localparam logic [N2W-1:0] N2_HI = N2W'(N2_MAX);
  localparam wide_t RMIN = (64'(VCO_MIN_KHZ) * INV) >> FRAC;
  localparam wide_t RMAX = (64'(VCO_MAX_KHZ) * INV) >> FRAC;

  logic [RW-1:0]  ratio_c, ratio_q;
  logic           clamp_c;
  logic [N1W-1:0] n1_q;
  logic [N2W-1:0] n2_q;
  logic           cand_ok;
  logic [MW-1:0]  cand_m;
  logic [RW-1:0]  cand_err, cand_den;
  logic [RW-1:0]  best_err, best_den;
  logic [MW-1:0]  best_m;
  logic [N1W-1:0] best_n1;
  logic [N2W-1:0] best_n2;
  logic           better;

  pll_freq_clamp #(
    .TW(TW), .RW(RW), .FRAC(FRAC), .INV(INV),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ), .N2_MAX(N2_MAX)
  ) u_clamp (
    .target(target_khz), .ratio(ratio_c), .was_clamped(clamp_c)
  );

  pll_pair_eval #(
    .RW(RW), .FRAC(FRAC), .N1W(N1W), .N2W(N2W), .MW(MW),
    .M_LO(M_MIN_ST + 2), .M_HI(M_MAX_ST + 2), .RMIN(RMIN), .RMAX(RMAX)
  ) u_eval (
    .ratio(ratio_q), .n1(n1_q), .n2(n2_q), .ok(cand_ok),
    .m_eff(cand_m), .err(cand_err), .den(cand_den)
  );

  // strictly smaller error, compared as exact fractions
  assign better = cand_ok &&
                  ((64'(cand_err) * 64'(best_den)) < (64'(best_err) * 64'(cand_den)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      clamped  <= 1'b0;
      ratio_q  <= '0;
      n1_q     <= N1_LO;
      n2_q     <= '0;
      best_err <= '0;
      best_den <= RW'(1);
      best_m   <= MW'(DEF_M);
      best_n1  <= N1W'(DEF_N1);
      best_n2  <= N2W'(DEF_N2);
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          clamped  <= clamp_c;
          ratio_q  <= ratio_c;
          n1_q     <= N1_LO;
          n2_q     <= '0;
          best_err <= ratio_c;
          best_den <= RW'(1);
          best_m   <= MW'(DEF_M);
          best_n1  <= N1W'(DEF_N1);
          best_n2  <= N2W'(DEF_N2);
        end
      end else begin
        if (better) begin
          best_err <= cand_err;
          best_den <= cand_den;
          best_m   <= cand_m;
          best_n1  <= n1_q;
          best_n2  <= n2_q;
        end
        if (n1_q == N1_HI) begin
          n1_q <= N1_LO;
          if (n2_q == N2_HI) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            n2_q <= n2_q + 1'b1;
          end
        end else begin
          n1_q <= n1_q + 1'b1;
        end
      end
    end
  end

  logic [BYTE_W-1:0] n1_field, n2_field;
  assign m_byte   = BYTE_W'(best_m - MW'(2));
  assign n1_field = BYTE_W'(best_n1 - N1W'(2));

  generate
    if (N1_MAX_ST == 63) begin : g_wide_n1
      assign n2_field = BYTE_W'(best_n2) << 6;
    end else begin : g_narrow_n1
      assign n2_field = BYTE_W'(best_n2) << 5;
    end
  endgenerate

  assign n_byte = n1_field | n2_field;
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       clamped,
  input logic [7:0] m_byte,
  input logic [7:0] n_byte
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                          // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                          // R2
  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                               // R2
  AST_CLAMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(clamped));                               // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(m_byte) && $stable(n_byte))); // R3
  AST_M_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (m_byte >= 8'd1 && m_byte <= 8'd127));           // R6
  AST_N1_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (n_byte[4:0] != 5'd0));                          // R9
endmodule

bind pll_div_search pll_div_search_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .clamped(clamped), .m_byte(m_byte), .n_byte(n_byte)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [18:0] target_khz = '0;
  logic        busy, done, clamped;
  logic [7:0]  m_byte, n_byte;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .busy(busy), .done(done), .clamped(clamped), .m_byte(m_byte), .n_byte(n_byte)
  );

  localparam longint INV  = 76791298;
  localparam longint RMIN = (100000 * INV) >> 20;
  localparam longint RMAX = (250000 * INV) >> 20;

  // model state
  bit     m_busy = 0, m_done = 0;
  int     m_cnt = 0;
  logic [7:0] e_m = 8'd125, e_n = 8'h50;
  bit     e_c = 0;

  task automatic expect_result(input longint f, output logic [7:0] mb,
                               output logic [7:0] nb, output bit cl);
    longint fc, r, bn, bd, bm, b1, b2;
    cl = (f < 12500) || (f > 250000);
    fc = (f < 12500) ? 12500 : ((f > 250000) ? 250000 : f);
    r  = (fc * INV) >> 20;
    bn = r; bd = 1; bm = 127; b1 = 18; b2 = 2;
    for (int n2 = 0; n2 <= 3; n2++) begin
      for (int n1 = 3; n1 <= 33; n1++) begin
        longint p, m, mq, e, d;
        p  = (r * n1) << n2;
        m  = (p + (64'd1 << 19)) >> 20;
        mq = m << 20;
        if (m < 3 || m > 129) continue;
        if (mq < n1 * RMIN || mq > n1 * RMAX) continue;
        e = (p >= mq) ? p - mq : mq - p;
        d = longint'(n1) << n2;
        if (e * bd < bn * d) begin
          bn = e; bd = d; bm = m; b1 = n1; b2 = n2;
        end
      end
    end
    mb = 8'(bm - 2);
    nb = 8'(b1 - 2) | (8'(b2) << 5);
  endtask

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // cycle model, follows the requirements
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin
          m_busy = 1; m_cnt = 0;
          expect_result(longint'(target_khz), e_m, e_n, e_c);
        end
      end else begin
        m_cnt++;
        if (m_cnt == 124) begin m_busy = 0; m_done = 1; end
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(busy == m_busy, "R2 busy", busy, m_busy);
      check(done == m_done, "R2 done", done, m_done);
      if (m_done) begin
        check(m_byte == e_m, "R5 R6 R7 R8 R9 m_byte", m_byte, e_m);
        check(n_byte == e_n, "R5 R6 R7 R8 R9 n_byte", n_byte, e_n);
        check(clamped == e_c, "R4 clamped", clamped, e_c);
      end
    end
  end

  task automatic run_case(input int f, input bit inject, input bit exp_clamp);
    int guard = 0;
    @(negedge clk);
    target_khz = 19'(f);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (20) @(negedge clk);
      target_khz = 19'd300000;   // R3: ignored while busy
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1, "R3 busy kept", busy, 1);
    end
    while (!done && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    check(clamped == exp_clamp, "R4 clamp flag", clamped, exp_clamp);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(clamped == 1'b0, "R1 clamped", clamped, 0);
    check(m_byte == 8'd125, "R1 m_byte", m_byte, 125);
    check(n_byte == 8'h50, "R1 n_byte", n_byte, 8'h50);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(25175, 0, 0);
    run_case(28322, 0, 0);
    run_case(40000, 0, 0);
    run_case(65000, 1, 0);
    run_case(108000, 0, 0);
    run_case(135000, 0, 0);
    run_case(12500, 0, 0);
    run_case(250000, 0, 0);
    run_case(5000, 0, 1);
    run_case(300000, 0, 1);
    run_case(31500, 1, 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule